// File: doc/BRIEF.md
# Two-Port Parallel Interface Register File

This block is the processor-facing register side of an adapter with two 8-bit parallel ports, A and B. A 2-bit offset reaches four slots: for each port, one data slot and one control slot. The data slot is shared by two registers. Control bit 2 of that port decides whether the slot reaches the output latch or the direction register. Each port drives the output latch masked by its direction bits. It also exposes the direction register as a per-bit output-enable vector, so a pad ring can build tri-state pins.

Reads are synchronous. A data read merges the driven bits with a registered sample of the pins. A control read returns the six writable bits together with two interrupt flags that come from the neighbouring handshake logic. Accesses that touch the data path emit one-cycle pulses toward that handshake logic: one for each port's data read, and one for a port B data write. A configuration input can swap the two middle offsets, for buses whose address wiring has them the other way round.

Top module: `ppi_regfile`

## Requirements
- R1: While reset is held, and until the first access, the output latches, direction registers, control registers and read data are all zero. Every pulse output is low and both port drives are zero.
- R2: Once remapped, offset 0 is the port A data slot, 1 is the port A control slot, 2 is the port B data slot and 3 is the port B control slot. With `swap_order` high, offsets 1 and 2 exchange before decoding (0→0, 1→2, 2→1, 3→3).
- R3: A data-slot write goes to the output latch when control bit 2 of that port is 1, and to the direction register when it is 0. `pa_oe`/`pb_oe` equal the direction register.
- R4: A data-slot read with control bit 2 set returns (latch & dir) | (pin_sample & ~dir). With bit 2 clear it returns the direction register.
- R5: A write to the output latch stores all 8 bits. `pa_out`/`pb_out` show latch & dir, so bits stored under a cleared direction bit appear once that bit is later set.
- R6: A control write stores only wdata[5:0]. A control read returns bit 7 = first interrupt flag input and bit 6 = second flag input gated off while control bit 5 is 1, with bits 5:0 as stored.
- R7: `rdata` changes only on the clock edge that samples a selected read, so it is valid in the cycle after the strobe. It holds its value at every other edge.
- R8: `rd_data_a`/`rd_data_b` pulse high for one cycle, in the cycle after a data-slot read of that port made with control bit 2 set. A direction read gives no pulse.
- R9: `wr_data_b` pulses high for one cycle after a port B data-slot write with port B control bit 2 set. Direction writes and port A writes give no pulse.
- R10: The pins pass through one register stage before they reach the read merge, so a read returns the pin value from the edge before the read's edge. The port A sample resets to all ones and the port B sample resets to all zeros.
- R11: With `cs` low, read and write strobes change no register, no output and no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| swap_order | input | 1 | Exchange offsets 1 and 2 |
| pa_in | input | 8 | Port A pin levels |
| pb_in | input | 8 | Port B pin levels |
| flag_a1 | input | 1 | Port A first interrupt flag |
| flag_a2 | input | 1 | Port A second interrupt flag |
| flag_b1 | input | 1 | Port B first interrupt flag |
| flag_b2 | input | 1 | Port B second interrupt flag |
| rdata | output | 8 | Registered read data |
| pa_out | output | 8 | Port A drive value (latch & dir) |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_out | output | 8 | Port B drive value (latch & dir) |
| pb_oe | output | 8 | Port B per-bit output enable |
| ctl_a | output | 6 | Port A control bits to handshake logic |
| ctl_b | output | 6 | Port B control bits to handshake logic |
| rd_data_a | output | 1 | Port A data-read pulse |
| rd_data_b | output | 1 | Port B data-read pulse |
| wr_data_b | output | 1 | Port B data-write pulse |

## Verification
Register writes, read data and the three pulses all appear one clock edge after the strobe. The pins reach a read one edge earlier than the read's own edge, because of the sample stage. The bench drives inputs on the falling edge and computes the reference model's next state from the inputs present before the rising edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Directed checks cover the sample-stage latency: the pins change in the same cycle as a read, so the old value is expected first and the new value on the next read.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    localparam int unsigned NPORT       = 2;
    localparam int unsigned SEL_OUT_BIT = 2;   // 1: data slot hits output latch
    localparam int unsigned C2_DIR_BIT  = 5;   // 1: second control line is an output

    typedef enum logic [1:0] {
        SLOT_A_DATA = 2'd0,
        SLOT_A_CTL  = 2'd1,
        SLOT_B_DATA = 2'd2,
        SLOT_B_CTL  = 2'd3
    } slot_e;

    // Exchanging the two offset bits maps 1<->2 and leaves 0 and 3 alone.
    function automatic slot_e map_offset(input logic [1:0] off, input logic swap);
        return swap ? slot_e'({off[0], off[1]}) : slot_e'(off);
    endfunction

endpackage

// File: rtl/ppi_addr_decode.sv
module ppi_addr_decode
    import ppi_pkg::*;
#(
    parameter int unsigned PORTS = NPORT
) (
    input  logic [1:0]       addr,
    input  logic             swap_order,
    input  logic             cs,
    output logic [PORTS-1:0] sel_data,
    output logic [PORTS-1:0] sel_ctl
);

    slot_e slot;

    always_comb begin
        slot = map_offset(addr, swap_order);
    end

    // Bit 1 of the slot picks the port, bit 0 picks control versus data.
    for (genvar p = 0; p < PORTS; p++) begin : g_sel
        localparam logic PBIT = 1'(p);
        always_comb begin
            sel_data[p] = cs && (slot[1] == PBIT) && !slot[0];
            sel_ctl[p]  = cs && (slot[1] == PBIT) &&  slot[0];
        end
    end

endmodule

// File: rtl/ppi_port.sv
module ppi_port
    import ppi_pkg::*;
#(
    parameter int unsigned       DATA_W  = 8,
    parameter int unsigned       CTL_W   = 6,
    parameter logic [DATA_W-1:0] PIN_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_data,
    input  logic              sel_ctl,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              flag1,
    input  logic              flag2,
    output logic [DATA_W-1:0] drive,
    output logic [DATA_W-1:0] oe,
    output logic [CTL_W-1:0]  ctl,
    output logic [DATA_W-1:0] rd_word,
    output logic              data_rd_hit,
    output logic              data_wr_hit
);

    localparam int unsigned FLAG1_BIT = DATA_W - 1;
    localparam int unsigned FLAG2_BIT = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] latch;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] pin;
        logic [CTL_W-1:0]  ctl;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     out_sel;

    always_comb begin
        out_sel = st_q.ctl[SEL_OUT_BIT];
        st_d    = st_q;
        st_d.pin = pin_in;
        if (wr_en && sel_ctl) begin
            st_d.ctl = wdata[CTL_W-1:0];
        end
        if (wr_en && sel_data) begin
            if (out_sel) begin
                st_d.latch = wdata;
            end else begin
                st_d.dir = wdata;
            end
        end

        rd_word = '0;
        if (sel_ctl) begin
            rd_word[CTL_W-1:0] = st_q.ctl;
            rd_word[FLAG1_BIT] = flag1;
            rd_word[FLAG2_BIT] = flag2 & ~st_q.ctl[C2_DIR_BIT];
        end else if (sel_data) begin
            rd_word = out_sel ? ((st_q.latch & st_q.dir) | (st_q.pin & ~st_q.dir))
                              : st_q.dir;
        end

        data_rd_hit = rd_en && sel_data && out_sel;
        data_wr_hit = wr_en && sel_data && out_sel;

        drive = st_q.latch & st_q.dir;
        oe    = st_q.dir;
        ctl   = st_q.ctl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '0;
            st_q.dir   <= '0;
            st_q.pin   <= PIN_RST;
            st_q.ctl   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ppi_regfile.sv
module ppi_regfile
    import ppi_pkg::*;
#(
    parameter int unsigned       DATA_W     = 8,
    parameter int unsigned       CTL_W      = 6,
    parameter logic [DATA_W-1:0] PA_PIN_RST = '1,
    parameter logic [DATA_W-1:0] PB_PIN_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              swap_order,
    input  logic [DATA_W-1:0] pa_in,
    input  logic [DATA_W-1:0] pb_in,
    input  logic              flag_a1,
    input  logic              flag_a2,
    input  logic              flag_b1,
    input  logic              flag_b2,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    output logic [CTL_W-1:0]  ctl_a,
    output logic [CTL_W-1:0]  ctl_b,
    output logic              rd_data_a,
    output logic              rd_data_b,
    output logic              wr_data_b
);

    localparam int unsigned PA = 0;
    localparam int unsigned PB = 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rd_a;
        logic              rd_b;
        logic              wr_b;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              rd_en, wr_en;
    logic [NPORT-1:0]  sel_data, sel_ctl;
    logic [NPORT-1:0]  rd_hit, wr_hit;
    logic [NPORT-1:0]  flag1_v, flag2_v;
    logic [DATA_W-1:0] pin_v   [NPORT];
    logic [DATA_W-1:0] drive_v [NPORT];
    logic [DATA_W-1:0] oe_v    [NPORT];
    logic [DATA_W-1:0] word_v  [NPORT];
    logic [CTL_W-1:0]  ctl_v   [NPORT];
    logic [DATA_W-1:0] word_sel;

    always_comb begin
        rd_en       = cs && rd;
        wr_en       = cs && wr;
        pin_v[PA]   = pa_in;
        pin_v[PB]   = pb_in;
        flag1_v[PA] = flag_a1;
        flag1_v[PB] = flag_b1;
        flag2_v[PA] = flag_a2;
        flag2_v[PB] = flag_b2;
    end

    ppi_addr_decode #(
        .PORTS (NPORT)
    ) i_decode (
        .addr       (addr),
        .swap_order (swap_order),
        .cs         (cs),
        .sel_data   (sel_data),
        .sel_ctl    (sel_ctl)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [DATA_W-1:0] RSTV = (p == PA) ? PA_PIN_RST : PB_PIN_RST;
        ppi_port #(
            .DATA_W  (DATA_W),
            .CTL_W   (CTL_W),
            .PIN_RST (RSTV)
        ) i_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_data    (sel_data[p]),
            .sel_ctl     (sel_ctl[p]),
            .rd_en       (rd_en),
            .wr_en       (wr_en),
            .wdata       (wdata),
            .pin_in      (pin_v[p]),
            .flag1       (flag1_v[p]),
            .flag2       (flag2_v[p]),
            .drive       (drive_v[p]),
            .oe          (oe_v[p]),
            .ctl         (ctl_v[p]),
            .rd_word     (word_v[p]),
            .data_rd_hit (rd_hit[p]),
            .data_wr_hit (wr_hit[p])
        );
    end

    // Unselected ports return zero words, so an OR gives the selected one.
    always_comb begin
        word_sel = '0;
        for (int p = 0; p < NPORT; p++) begin
            word_sel = word_sel | word_v[p];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.rd_a = rd_hit[PA];
        st_d.rd_b = rd_hit[PB];
        st_d.wr_b = wr_hit[PB];
        if (rd_en) begin
            st_d.rdata = word_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata     = st_q.rdata;
        rd_data_a = st_q.rd_a;
        rd_data_b = st_q.rd_b;
        wr_data_b = st_q.wr_b;
        pa_out    = drive_v[PA];
        pa_oe     = oe_v[PA];
        pb_out    = drive_v[PB];
        pb_oe     = oe_v[PB];
        ctl_a     = ctl_v[PA];
        ctl_b     = ctl_v[PB];
    end

endmodule

// File: rtl/ppi_regfile_sva.sv
module ppi_regfile_sva #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTL_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pb_out,
    input logic [DATA_W-1:0] pb_oe,
    input logic [CTL_W-1:0]  ctl_a,
    input logic [CTL_W-1:0]  ctl_b,
    input logic              rd_data_a,
    input logic              rd_data_b,
    input logic              wr_data_b
);

    AST_DRIVE_WITHIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_out & ~pa_oe) == '0) && ((pb_out & ~pb_oe) == '0)); // R5

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs && rd) |-> $stable(rdata)); // R7

    AST_RD_PULSE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_a || rd_data_b) |-> $past(cs && rd)); // R8

    AST_ONE_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_data_a, rd_data_b})); // R8

    AST_WR_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_b |-> $past(cs && wr)); // R9

    AST_IDLE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs && wr) |-> ($stable(ctl_a) && $stable(ctl_b) &&
                              $stable(pa_oe) && $stable(pb_oe))); // R11

endmodule

bind ppi_regfile ppi_regfile_sva #(
    .DATA_W (DATA_W),
    .CTL_W  (CTL_W)
) i_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .rd        (rd),
    .wr        (wr),
    .rdata     (rdata),
    .pa_out    (pa_out),
    .pa_oe     (pa_oe),
    .pb_out    (pb_out),
    .pb_oe     (pb_oe),
    .ctl_a     (ctl_a),
    .ctl_b     (ctl_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .wr_data_b (wr_data_b)
);

// File: tb/test_ppi_regfile.sv
module test_ppi_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       swap_order = 1'b0;
    logic [7:0] pa_in = 8'h3C, pb_in = 8'hC3;
    logic       flag_a1 = 1'b0, flag_a2 = 1'b0, flag_b1 = 1'b0, flag_b2 = 1'b0;
    logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe;
    logic [5:0] ctl_a, ctl_b;
    logic       rd_data_a, rd_data_b, wr_data_b;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    ppi_regfile i_ppi_regfile (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .swap_order(swap_order), .pa_in(pa_in), .pb_in(pb_in),
        .flag_a1(flag_a1), .flag_a2(flag_a2), .flag_b1(flag_b1), .flag_b2(flag_b2),
        .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_data_b(wr_data_b)
    );

    // Reference model state
    logic [7:0] m_lat [2] = '{8'h00, 8'h00};
    logic [7:0] m_dir [2] = '{8'h00, 8'h00};
    logic [5:0] m_ctl [2] = '{6'h00, 6'h00};
    logic [7:0] m_pin [2] = '{8'hFF, 8'h00};
    logic [7:0] m_rdata = 8'h00;
    bit         m_rda = 0, m_rdb = 0, m_wrb = 0;
    int         remap [4] = '{0, 2, 1, 3};

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R5", "pa_out", pa_out, m_lat[0] & m_dir[0]);
        chk("R5", "pb_out", pb_out, m_lat[1] & m_dir[1]);
        chk("R3", "pa_oe", pa_oe, m_dir[0]);
        chk("R3", "pb_oe", pb_oe, m_dir[1]);
        chk("R6", "ctl_a", {2'b00, ctl_a}, {2'b00, m_ctl[0]});
        chk("R6", "ctl_b", {2'b00, ctl_b}, {2'b00, m_ctl[1]});
        chk("R4", "rdata", rdata, m_rdata);
        chk("R8", "rd_data_a", {7'd0, rd_data_a}, {7'd0, m_rda});
        chk("R8", "rd_data_b", {7'd0, rd_data_b}, {7'd0, m_rdb});
        chk("R9", "wr_data_b", {7'd0, wr_data_b}, {7'd0, m_wrb});
    endtask

    // One clock: predict from inputs before the edge, then compare after it.
    task automatic cyc();
        logic [7:0] n_lat [2];
        logic [7:0] n_dir [2];
        logic [5:0] n_ctl [2];
        logic [7:0] n_rdata;
        bit nra, nrb, nwb;
        int slot, p;
        bit is_ctl;
        logic f1, f2;
        n_lat = m_lat; n_dir = m_dir; n_ctl = m_ctl;
        n_rdata = m_rdata; nra = 0; nrb = 0; nwb = 0;
        slot   = swap_order ? remap[addr] : int'(addr);
        p      = slot / 2;
        is_ctl = (slot % 2) == 1;
        f1 = (p == 0) ? flag_a1 : flag_b1;
        f2 = (p == 0) ? flag_a2 : flag_b2;
        if (cs && rd) begin
            if (is_ctl) begin
                n_rdata = {f1, f2 && !m_ctl[p][5], m_ctl[p]};
            end else if (m_ctl[p][2]) begin
                n_rdata = (m_lat[p] & m_dir[p]) | (m_pin[p] & ~m_dir[p]);
                if (p == 0) nra = 1; else nrb = 1;
            end else begin
                n_rdata = m_dir[p];
            end
        end
        if (cs && wr) begin
            if (is_ctl) n_ctl[p] = wdata[5:0];
            else if (m_ctl[p][2]) begin
                n_lat[p] = wdata;
                if (p == 1) nwb = 1;
            end else n_dir[p] = wdata;
        end
        @(posedge clk);
        m_lat = n_lat; m_dir = n_dir; m_ctl = n_ctl;
        m_pin[0] = pa_in; m_pin[1] = pb_in;
        m_rdata = n_rdata; m_rda = nra; m_rdb = nrb; m_wrb = nwb;
        @(negedge clk);
        compare_all();
    endtask

    task automatic acc(input bit do_wr, input logic [1:0] off, input logic [7:0] d);
        cs = 1'b1; wr = do_wr; rd = !do_wr; addr = off; wdata = d;
        cyc();
        cs = 1'b0; wr = 1'b0; rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "rdata at reset", rdata, 8'h00);
        chk("R1", "pa_oe at reset", pa_oe, 8'h00);
        chk("R1", "ctl_a at reset", {2'b00, ctl_a}, 8'h00);
        chk("R1", "pulses at reset", {5'd0, rd_data_a, rd_data_b, wr_data_b}, 8'h00);
        rst_n = 1'b1;

        acc(1, 2'd0, 8'h0F);                 // direction A (bit 2 clear)
        chk("R3", "ddr A written", pa_oe, 8'h0F);
        acc(1, 2'd1, 8'hFF);
        chk("R6", "ctl A keeps 5:0", {2'b00, ctl_a}, 8'h3F);
        flag_a1 = 1'b1; flag_a2 = 1'b1;
        acc(0, 2'd1, 8'h00);
        chk("R6", "flag2 gated by bit5", rdata, 8'hBF);
        acc(1, 2'd1, 8'h04);
        acc(0, 2'd1, 8'h00);
        chk("R6", "both flags visible", rdata, 8'hC4);
        acc(1, 2'd0, 8'hA5);
        chk("R5", "masked drive", pa_out, 8'h05);
        chk("R3", "ddr unchanged by out write", pa_oe, 8'h0F);
        acc(0, 2'd0, 8'h00);
        chk("R4", "merged read A", rdata, 8'h35);
        chk("R8", "rd_data_a pulse", {7'd0, rd_data_a}, 8'h01);
        cyc();
        chk("R7", "rdata held", rdata, 8'h35);
        chk("R8", "rd_data_a one cycle", {7'd0, rd_data_a}, 8'h00);
        acc(1, 2'd1, 8'h00);
        acc(0, 2'd0, 8'h00);
        chk("R4", "ddr read A", rdata, 8'h0F);
        chk("R8", "no pulse on ddr read", {7'd0, rd_data_a}, 8'h00);
        acc(1, 2'd0, 8'hFF);
        chk("R5", "stored bits re-exposed", pa_out, 8'hA5);

        acc(1, 2'd3, 8'h04);
        acc(1, 2'd2, 8'h55);
        chk("R9", "wr_data_b pulse", {7'd0, wr_data_b}, 8'h01);
        chk("R5", "pb hidden under ddr 0", pb_out, 8'h00);
        acc(1, 2'd3, 8'h00);
        acc(1, 2'd2, 8'hF0);
        chk("R9", "no pulse on ddr write", {7'd0, wr_data_b}, 8'h00);
        acc(1, 2'd3, 8'h04);
        chk("R5", "pb drive", pb_out, 8'h50);
        acc(0, 2'd2, 8'h00);
        chk("R4", "merged read B", rdata, 8'h53);
        chk("R8", "rd_data_b pulse", {7'd0, rd_data_b}, 8'h01);

        swap_order = 1'b1;
        acc(0, 2'd1, 8'h00);
        chk("R2", "swapped offset 1 is B data", rdata, 8'h53);
        acc(0, 2'd2, 8'h00);
        chk("R2", "swapped offset 2 is A ctl", rdata, 8'hC0);
        swap_order = 1'b0;

        cs = 1'b0; wr = 1'b1; rd = 1'b1; addr = 2'd0; wdata = 8'h00;
        cyc();
        wr = 1'b0; rd = 1'b0;
        chk("R11", "no-cs write ignored", pa_oe, 8'hFF);
        chk("R11", "no-cs read ignored", rdata, 8'hC0);

        acc(1, 2'd0, 8'h00);                 // ddr A = 0, ctl A bit2 = 0
        acc(1, 2'd1, 8'h04);
        pa_in = 8'h99;
        acc(0, 2'd0, 8'h00);
        chk("R10", "read sees previous sample", rdata, 8'h3C);
        acc(0, 2'd0, 8'h00);
        chk("R10", "read sees new sample", rdata, 8'h99);

        for (int i = 0; i < 600; i++) begin
            cs = ($urandom_range(0, 7) != 0);
            rd = $urandom_range(0, 1);
            wr = $urandom_range(0, 1);
            addr = 2'($urandom_range(0, 3));
            wdata = 8'($urandom);
            swap_order = $urandom_range(0, 1);
            pa_in = 8'($urandom);
            pb_in = 8'($urandom);
            flag_a1 = $urandom_range(0, 1); flag_a2 = $urandom_range(0, 1);
            flag_b1 = $urandom_range(0, 1); flag_b2 = $urandom_range(0, 1);
            cyc();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule